// File: doc/BRIEF.md
# Selectable Clock Divider Bank

This block takes one fast source clock and turns it into nine divided clock outputs arranged in four banks. Bank A and bank B each drive one output, bank C drives two and bank D drives five. Each bank has its own select bit, and that bit chooses one of two even division ratios. Every output therefore has a 50% duty cycle. All ratios are taken from one free-running counter, so the rising edges of every bank line up.

The clock that feeds the divider comes from a small source selector. When the oscillator path is enabled, the fast oscillator clock is used. When it is bypassed, one of two reference clocks is used: a test clock or the primary reference. A single combined input clears all divider state and disables every output. While that input is high, the outputs are driven to high impedance and a per-output enable vector reads zero. Reset is applied asynchronously and released in step with the selected source clock.

Top module: `clk_div_bank`

## Requirements
- R1: Bank A divides the source clock by 2 when `sel[0]` is 0 and by 4 when `sel[0]` is 1. The output is high for exactly half of each period.
- R2: Banks B, C and D use select bits `sel[1]`, `sel[2]` and `sel[3]`. Each of these banks divides by 4 when its bit is 0 and by 8 when its bit is 1, with 50% duty.
- R3: Both bank C outputs always carry the same level. All five bank D outputs always carry the same level.
- R4: All outputs are phase aligned to one count. Let m be the number of counting source edges since reset release. An output with ratio N is high exactly when (m mod N) < N/2, so all nine outputs rise together at every count of zero.
- R5: While `mr_oe` is 1, all nine outputs are in high impedance and every bit of `out_en` is 0. Both take effect without waiting for a clock edge. `out_en` bit 0 is A, bit 1 is B, bits 3:2 are C and bits 8:4 are D.
- R6: `mr_oe` high clears the divider to count zero. After `mr_oe` falls, the first two rising edges of the selected source only release the reset, and all outputs stay high. Counting starts on the third edge.
- R7: When `pll_on` is 1, `vco_clk` drives the divider, and edges on `test_clk` or `ref_clk` have no effect on the outputs.
- R8: When `pll_on` is 0 and `use_test_ref` is 1, `test_clk` drives the divider, and `vco_clk` and `ref_clk` have no effect.
- R9: When `pll_on` is 0 and `use_test_ref` is 0, `ref_clk` drives the divider, and `vco_clk` and `test_clk` have no effect.
- R10: A change of a select bit changes that bank's output at once, with no clock edge needed. The counter phase is not reset, so the bank continues at the new ratio from the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | Fast oscillator clock, used when `pll_on` is 1 |
| ref_clk | input | 1 | Primary reference clock, used in bypass when `use_test_ref` is 0 |
| test_clk | input | 1 | Test clock, used in bypass when `use_test_ref` is 1 |
| pll_on | input | 1 | 1 selects the oscillator clock; 0 bypasses it in favour of a reference |
| use_test_ref | input | 1 | Reference choice in bypass: 1 selects the test clock, 0 the primary reference |
| mr_oe | input | 1 | 1 clears the divider and disables all outputs; 0 runs and enables them |
| sel | input | 4 | Ratio select bits: bit 0 for A, bit 1 for B, bit 2 for C, bit 3 for D |
| out_a | output | 1 | Bank A clock |
| out_b | output | 1 | Bank B clock |
| out_c | output | 2 | Bank C clocks |
| out_d | output | 5 | Bank D clocks |
| out_en | output | 9 | Per-output drive enable, in the bit order given in R5 |

## Verification
The bench steps the select bits through all sixteen combinations on the running oscillator clock. At every source cycle it compares each output with the count-based pattern from R4. This separates a wrong counter bit, a ratio swap between banks, a lost duty cycle and any phase slip between banks. The bench also changes the select bits between clock edges and checks the outputs before the next edge, which tells combinational selection apart from a registered one.

The bench raises `mr_oe` in the middle of a run and releases it again. This checks that the enables drop at once and that counting restarts exactly on the third edge after release. It then drives each bypass source by hand while pulsing the clocks that are not selected. Any leak from an unselected clock into the divider shows up as a moved output.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

  // Counter width: bit k of the counter divides the source by 2**(k+1)
  localparam int CNT_W = 3;

  // Fastest counter bit each bank can use (bank A: /2, banks B-D: /4)
  localparam int A_FAST_BIT   = 0;
  localparam int BCD_FAST_BIT = 1;

  // A set select bit moves the bank one counter bit slower (doubles the ratio)
  function automatic int pick_bit(input int fast_bit, input logic slow_sel);
    return fast_bit + (slow_sel ? 1 : 0);
  endfunction

  // Division ratio that a counter bit gives
  function automatic int bit_ratio(input int bit_idx);
    return 2 << bit_idx;
  endfunction

endpackage

// File: rtl/cdb_src_mux.sv
module cdb_src_mux (
  input  logic vco_clk,
  input  logic ref_clk,
  input  logic test_clk,
  input  logic pll_on,
  input  logic use_test_ref,
  output logic src_clk
);

  logic ref_pick;

  assign ref_pick = use_test_ref ? test_clk : ref_clk;
  assign src_clk  = pll_on ? vco_clk : ref_pick;

endmodule

// File: rtl/cdb_rst_sync.sv
module cdb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cdb_counter.sv
module cdb_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/cdb_bank.sv
module cdb_bank #(
  parameter int N_OUT    = 1,
  parameter int FAST_BIT = 0,
  parameter int CNT_W    = 3
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             slow_sel,
  input  logic             oe,
  output logic [N_OUT-1:0] val,
  output logic [N_OUT-1:0] en,
  output logic [N_OUT-1:0] pin
);

  logic level;

  // The inverted counter bit rises when the lower bits wrap to zero,
  // so all banks rise together at count zero
  assign level = ~cnt[cdb_pkg::pick_bit(FAST_BIT, slow_sel)];

  for (genvar i = 0; i < N_OUT; i++) begin : g_copy
    assign val[i] = level;
    assign en[i]  = oe;
    assign pin[i] = oe ? level : 1'bz;
  end

endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank #(
  parameter int N_C         = 2,
  parameter int N_D         = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               vco_clk,
  input  logic               ref_clk,
  input  logic               test_clk,
  input  logic               pll_on,
  input  logic               use_test_ref,
  input  logic               mr_oe,
  input  logic [3:0]         sel,
  output logic               out_a,
  output logic               out_b,
  output logic [N_C-1:0]     out_c,
  output logic [N_D-1:0]     out_d,
  output logic [N_C+N_D+1:0] out_en
);

  localparam int CNT_W = cdb_pkg::CNT_W;

  // Internal events brought out as named wires
  logic             src_clk;
  logic             core_rst_n;
  logic [CNT_W-1:0] cnt;
  logic             out_on;
  logic [0:0]       a_val, a_en, b_val, b_en;
  logic [N_C-1:0]   c_val, c_en;
  logic [N_D-1:0]   d_val, d_en;

  assign out_on = ~mr_oe;

  cdb_src_mux u_mux (
    .vco_clk      (vco_clk),
    .ref_clk      (ref_clk),
    .test_clk     (test_clk),
    .pll_on       (pll_on),
    .use_test_ref (use_test_ref),
    .src_clk      (src_clk)
  );

  cdb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (src_clk),
    .arst_n (out_on),
    .rst_n  (core_rst_n)
  );

  cdb_counter #(.W(CNT_W)) u_cnt (
    .clk   (src_clk),
    .rst_n (core_rst_n),
    .cnt   (cnt)
  );

  cdb_bank #(.N_OUT(1), .FAST_BIT(cdb_pkg::A_FAST_BIT), .CNT_W(CNT_W)) u_bank_a (
    .cnt (cnt), .slow_sel (sel[0]), .oe (out_on),
    .val (a_val), .en (a_en), .pin (out_a)
  );

  cdb_bank #(.N_OUT(1), .FAST_BIT(cdb_pkg::BCD_FAST_BIT), .CNT_W(CNT_W)) u_bank_b (
    .cnt (cnt), .slow_sel (sel[1]), .oe (out_on),
    .val (b_val), .en (b_en), .pin (out_b)
  );

  cdb_bank #(.N_OUT(N_C), .FAST_BIT(cdb_pkg::BCD_FAST_BIT), .CNT_W(CNT_W)) u_bank_c (
    .cnt (cnt), .slow_sel (sel[2]), .oe (out_on),
    .val (c_val), .en (c_en), .pin (out_c)
  );

  cdb_bank #(.N_OUT(N_D), .FAST_BIT(cdb_pkg::BCD_FAST_BIT), .CNT_W(CNT_W)) u_bank_d (
    .cnt (cnt), .slow_sel (sel[3]), .oe (out_on),
    .val (d_val), .en (d_en), .pin (out_d)
  );

  assign out_en = {d_en, c_en, b_en, a_en};

endmodule

// File: rtl/clk_div_bank_chk.sv
module clk_div_bank_chk #(
  parameter int CNT_W = 3,
  parameter int N_C   = 2,
  parameter int N_D   = 5
) (
  input logic               src_clk,
  input logic               core_rst_n,
  input logic               mr_oe,
  input logic [3:0]         sel,
  input logic [CNT_W-1:0]   cnt,
  input logic [0:0]         a_val,
  input logic [0:0]         b_val,
  input logic [N_C-1:0]     c_val,
  input logic [N_D-1:0]     d_val,
  input logic [N_C+N_D+1:0] out_en
);

  // R1
  a_div2_toggle_chk: assert property (@(posedge src_clk) disable iff (!core_rst_n || mr_oe)
    ($past(core_rst_n) && !sel[0] && !$past(sel[0])) |-> a_val != $past(a_val));

  // R2
  b_div4_half_chk: assert property (@(posedge src_clk) disable iff (!core_rst_n || mr_oe)
    ($past(core_rst_n, 2) && !sel[1] && !$past(sel[1]) && !$past(sel[1], 2))
      |-> b_val != $past(b_val, 2));

  // R3
  c_copies_chk: assert property (@(posedge src_clk) disable iff (!core_rst_n)
    c_val == {N_C{c_val[0]}});

  // R3
  d_copies_chk: assert property (@(posedge src_clk) disable iff (!core_rst_n)
    d_val == {N_D{d_val[0]}});

  // R4
  zero_align_chk: assert property (@(posedge src_clk) disable iff (!core_rst_n || mr_oe)
    (cnt == '0) |-> (a_val[0] && b_val[0] && (&c_val) && (&d_val)));

  // R5
  oe_off_chk: assert property (@(posedge src_clk) disable iff (core_rst_n)
    mr_oe |-> out_en == '0);

  // R6
  cnt_step_chk: assert property (@(posedge src_clk) disable iff (!core_rst_n || mr_oe)
    $past(core_rst_n) |-> cnt == $past(cnt) + 1'b1);

endmodule

bind clk_div_bank clk_div_bank_chk #(.CNT_W(cdb_pkg::CNT_W), .N_C(N_C), .N_D(N_D)) u_chk (
  .src_clk    (src_clk),
  .core_rst_n (core_rst_n),
  .mr_oe      (mr_oe),
  .sel        (sel),
  .cnt        (cnt),
  .a_val      (a_val),
  .b_val      (b_val),
  .c_val      (c_val),
  .d_val      (d_val),
  .out_en     (out_en)
);

// File: tb/clk_div_bank_tb.sv
`timescale 1ns/1ps
module clk_div_bank_tb;

  logic       vco_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       test_clk = 1'b0;
  logic       pll_on = 1'b1;
  logic       use_test_ref = 1'b0;
  logic       mr_oe = 1'b1;
  logic [3:0] sel = 4'h0;
  logic       out_a, out_b;
  logic [1:0] out_c;
  logic [4:0] out_d;
  logic [8:0] out_en;

  int checks = 0;
  int errors = 0;
  int m_cnt  = 0;
  bit done   = 1'b0;

  always #2.5 vco_clk = ~vco_clk;

  clk_div_bank u_dut (
    .vco_clk (vco_clk), .ref_clk (ref_clk), .test_clk (test_clk),
    .pll_on (pll_on), .use_test_ref (use_test_ref), .mr_oe (mr_oe),
    .sel (sel), .out_a (out_a), .out_b (out_b), .out_c (out_c),
    .out_d (out_d), .out_en (out_en)
  );

  // Ratio for a bank from the select bit (bank 0 = A)
  function automatic int ratio_of(int bank, logic s);
    if (bank == 0) return s ? 4 : 2;
    return s ? 8 : 4;
  endfunction

  // Level an output with ratio n must show m counting edges after release
  function automatic logic exp_level(int m, int n);
    int mm;
    mm = (m < 0) ? 0 : m;
    return ((mm % n) < (n / 2)) ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs(string req);
    logic ea, eb, ec, ed;
    ea = exp_level(m_cnt, ratio_of(0, sel[0]));
    eb = exp_level(m_cnt, ratio_of(1, sel[1]));
    ec = exp_level(m_cnt, ratio_of(2, sel[2]));
    ed = exp_level(m_cnt, ratio_of(3, sel[3]));
    chk(out_en == 9'h1FF, req, "out_en", int'(out_en), 9'h1FF);
    chk(out_a == ea, req, "out_a", int'(out_a), int'(ea));
    chk(out_b == eb, req, "out_b", int'(out_b), int'(eb));
    for (int i = 0; i < 2; i++) chk(out_c[i] == ec, req, "out_c", int'(out_c[i]), int'(ec));
    for (int i = 0; i < 5; i++) chk(out_d[i] == ed, req, "out_d", int'(out_d[i]), int'(ed));
  endtask

  // One source cycle on the oscillator clock, sampled after the falling edge
  task automatic step();
    @(negedge vco_clk);
    #1;
    m_cnt++;
  endtask

  task automatic pulse_test(bit counts);
    test_clk = 1'b1; #1; test_clk = 1'b0; #1;
    if (counts) m_cnt++;
  endtask

  task automatic pulse_ref(bit counts);
    ref_clk = 1'b1; #1; ref_clk = 1'b0; #1;
    if (counts) m_cnt++;
  endtask

  task automatic release_vco();
    @(negedge vco_clk);
    #1;
    mr_oe = 1'b0;
    m_cnt = -2;
  endtask

  // R5, R6: disabled state, then start-up from count zero
  task automatic t_reset_state();
    repeat (4) step();
    chk(out_en == 9'h000, "R5", "out_en in reset", int'(out_en), 0);
    release_vco();
    step();
    check_outs("R6 first edge");
    step();
    check_outs("R6 second edge");
    step();
    check_outs("R6 first count");
  endtask

  // R1 R2 R3 R4 R10: all sixteen select combinations on the oscillator clock
  task automatic t_all_selects();
    for (int combo = 0; combo < 16; combo++) begin
      sel = 4'(combo);
      #0.2;
      check_outs("R10 immediate");
      for (int k = 0; k < 8; k++) begin
        step();
        check_outs("R1 R2 R3 R4");
      end
    end
  endtask

  // R5, R6: disable in the middle of a run, then restart
  task automatic t_oe_midrun();
    sel = 4'b1010;
    mr_oe = 1'b1;
    #0.2;
    chk(out_en == 9'h000, "R5", "out_en immediate", int'(out_en), 0);
    repeat (3) step();
    chk(out_en == 9'h000, "R5", "out_en held", int'(out_en), 0);
    release_vco();
    for (int k = 0; k < 10; k++) begin
      step();
      check_outs("R6 restart");
    end
  endtask

  // R7: unselected clocks pulsed while the oscillator runs
  task automatic t_pll_ignores_refs();
    sel = 4'b0101;
    for (int k = 0; k < 12; k++) begin
      test_clk = 1'b1; #0.1; test_clk = 1'b0;
      ref_clk = 1'b1;  #0.1; ref_clk = 1'b0;
      step();
      check_outs("R7");
    end
  endtask

  // R8: test clock in bypass
  task automatic t_test_ref();
    sel = 4'b0000;
    mr_oe = 1'b1;
    #1;
    pll_on = 1'b0;
    use_test_ref = 1'b1;
    #3;
    mr_oe = 1'b0;
    m_cnt = -2;
    #1;
    pulse_test(1'b1);
    pulse_test(1'b1);
    check_outs("R8 released");
    repeat (6) @(negedge vco_clk);
    #1;
    check_outs("R8 oscillator ignored");
    repeat (3) pulse_ref(1'b0);
    check_outs("R8 reference ignored");
    for (int k = 0; k < 5; k++) begin
      pulse_test(1'b1);
      check_outs("R8 counting");
    end
  endtask

  // R9: primary reference in bypass
  task automatic t_primary_ref();
    sel = 4'b1001;
    mr_oe = 1'b1;
    #1;
    use_test_ref = 1'b0;
    #3;
    mr_oe = 1'b0;
    m_cnt = -2;
    #1;
    pulse_ref(1'b1);
    pulse_ref(1'b1);
    check_outs("R9 released");
    repeat (3) pulse_test(1'b0);
    repeat (4) @(negedge vco_clk);
    #1;
    check_outs("R9 others ignored");
    for (int k = 0; k < 9; k++) begin
      pulse_ref(1'b1);
      check_outs("R9 counting");
    end
    mr_oe = 1'b1;
    #1;
    pll_on = 1'b1;
  endtask

  initial begin
    t_reset_state();
    t_all_selects();
    t_oe_midrun();
    t_pll_ignores_refs();
    t_test_ref();
    t_primary_ref();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule